// File: doc/BRIEF.md
# Triggered Event Readout Controller

This controller sits between an external trigger source, a multi-channel digitizer and a host processor. Triggers arrive only while the veto output is low. Each accepted trigger raises the veto, starts a digitizer measurement and adds one to an event count. While the count is still below a configurable limit, the controller waits for the digitizer's ready signal after each measurement. It then drops the veto and pulses a clear-trigger output so that collection can go on.

When an accepted trigger brings the count up to the limit, the controller raises an interrupt request and holds it until the host reports that its read is done. The veto then stays high through the rest of the sequence. The host must reset the digitizer, and the digitizer must report ready, before the veto is released, the clear-trigger output pulses and the event count restarts from zero. A host reset that arrives in any state sends the controller to that final ready wait with the veto high.

Top module: `evt_readout_ctrl`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `veto_o`, `start_meas_o`, `irq_o` and `clr_trig_o` are all 0.
- R2: A high `trig_i` sampled while `veto_o` is 0 and `host_rst_i` is 0 drives `veto_o` to 1 and `start_meas_o` to 1 at that clock edge. `start_meas_o` lasts exactly one cycle.
- R3: `trig_i` sampled while `veto_o` is 1 has no effect: it produces no `start_meas_o` pulse and does not add to the event count.
- R4: After an accepted trigger that leaves the event count below `EVT_LIMIT` (default 5), `irq_o` stays 0 and `veto_o` stays 1 until `dig_ready_i` is sampled high. At that edge `veto_o` goes to 0 and `clr_trig_o` pulses for one cycle.
- R5: The accepted trigger that brings the event count to `EVT_LIMIT` sets `irq_o` to 1 at the same edge as its `start_meas_o` pulse.
- R6: `irq_o` stays 1 until `read_done_i` is sampled high, and falls at that edge. While the interrupt is pending, `dig_ready_i` does not clear `veto_o`.
- R7: After the read is done, `veto_o` stays 1 until `host_rst_i` has been seen and a later `dig_ready_i` is sampled. At that edge `veto_o` falls, `clr_trig_o` pulses and the event count returns to zero, so the next interrupt needs `EVT_LIMIT` new triggers.
- R8: A `host_rst_i` sampled high in any state drives `irq_o` to 0 and `veto_o` to 1 at that edge, and it wins over a trigger in the same cycle. The controller then waits for `dig_ready_i`, which clears the veto and the event count.
- R9: `dig_ready_i` or `read_done_i` sampled while the controller is collecting with `veto_o` at 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | External trigger request |
| host_rst_i | input | 1 | Host has reset the digitizer |
| dig_ready_i | input | 1 | Digitizer reports ready |
| read_done_i | input | 1 | Host has finished the readout |
| veto_o | output | 1 | Trigger veto, high blocks triggers |
| start_meas_o | output | 1 | One-cycle measurement start pulse |
| irq_o | output | 1 | Readout interrupt request to the host |
| clr_trig_o | output | 1 | One-cycle pulse marking veto release |

## Verification
The assertions take for granted that every input is a synchronous level sampled on the rising edge. They also assume that the host gives no read-done before it has seen the interrupt, because an early read-done is simply ignored. The bench changes inputs only on the falling edge and drives single-cycle pulses of each handshake input. It applies these pulses both in the states where they act and in states where they must be ignored, for example ready during a pending interrupt, read-done while collecting, and a trigger together with a host reset. A behavioural model in the bench is compared with all four outputs on every cycle.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  typedef enum logic [2:0] {
    S_COLLECT = 3'd0,
    S_MEAS    = 3'd1,
    S_IRQ     = 3'd2,
    S_HOSTRST = 3'd3,
    S_RECOVER = 3'd4
  } seq_state_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int EVT_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic inc_i,
  input  logic clr_i,
  output logic last_o
);
  localparam int CNT_W = (EVT_LIMIT > 1) ? $clog2(EVT_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(EVT_LIMIT - 1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      count_q <= '0;
    end else if (inc_i) begin
      if (count_q == LAST_VAL) count_q <= '0;
      else                     count_q <= count_q + 1'b1;
    end
  end

  assign last_o = (count_q == LAST_VAL);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import evt_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic host_rst_i,
  input  logic dig_ready_i,
  input  logic read_done_i,
  input  logic last_i,
  output logic inc_o,
  output logic clr_o,
  output logic veto_o,
  output logic start_meas_o,
  output logic irq_o,
  output logic clr_trig_o
);
  seq_state_t state_q, state_d;
  logic veto_d, irq_d, start_d, clrt_d;

  always_comb begin
    state_d = state_q;
    veto_d  = veto_o;
    irq_d   = irq_o;
    start_d = 1'b0;
    clrt_d  = 1'b0;
    inc_o   = 1'b0;
    clr_o   = 1'b0;
    if (host_rst_i) begin
      state_d = S_RECOVER;
      veto_d  = 1'b1;
      irq_d   = 1'b0;
    end else begin
      unique case (state_q)
        S_COLLECT: if (trig_i) begin
          inc_o   = 1'b1;
          veto_d  = 1'b1;
          start_d = 1'b1;
          if (last_i) begin
            irq_d   = 1'b1;
            state_d = S_IRQ;
          end else begin
            state_d = S_MEAS;
          end
        end
        S_MEAS: if (dig_ready_i) begin
          veto_d  = 1'b0;
          clrt_d  = 1'b1;
          state_d = S_COLLECT;
        end
        S_IRQ: if (read_done_i) begin
          irq_d   = 1'b0;
          state_d = S_HOSTRST;
        end
        S_HOSTRST: state_d = S_HOSTRST;
        S_RECOVER: if (dig_ready_i) begin
          veto_d  = 1'b0;
          clrt_d  = 1'b1;
          clr_o   = 1'b1;
          state_d = S_COLLECT;
        end
        default: begin
          state_d = S_RECOVER;
          veto_d  = 1'b1;
          irq_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_COLLECT;
      veto_o       <= 1'b0;
      irq_o        <= 1'b0;
      start_meas_o <= 1'b0;
      clr_trig_o   <= 1'b0;
    end else begin
      state_q      <= state_d;
      veto_o       <= veto_d;
      irq_o        <= irq_d;
      start_meas_o <= start_d;
      clr_trig_o   <= clrt_d;
    end
  end
endmodule

// File: rtl/evt_readout_ctrl.sv
module evt_readout_ctrl #(
  parameter int EVT_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic host_rst_i,
  input  logic dig_ready_i,
  input  logic read_done_i,
  output logic veto_o,
  output logic start_meas_o,
  output logic irq_o,
  output logic clr_trig_o
);
  logic cnt_inc, cnt_clr, cnt_last;

  evt_counter #(.EVT_LIMIT(EVT_LIMIT)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc_i  (cnt_inc),
    .clr_i  (cnt_clr),
    .last_o (cnt_last)
  );

  seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .host_rst_i   (host_rst_i),
    .dig_ready_i  (dig_ready_i),
    .read_done_i  (read_done_i),
    .last_i       (cnt_last),
    .inc_o        (cnt_inc),
    .clr_o        (cnt_clr),
    .veto_o       (veto_o),
    .start_meas_o (start_meas_o),
    .irq_o        (irq_o),
    .clr_trig_o   (clr_trig_o)
  );
endmodule

// File: rtl/evt_readout_chk.sv
module evt_readout_chk (
  input logic clk,
  input logic rst,
  input logic trig_i,
  input logic host_rst_i,
  input logic dig_ready_i,
  input logic read_done_i,
  input logic veto_o,
  input logic start_meas_o,
  input logic irq_o,
  input logic clr_trig_o
);
  // R2
  trig_accept_chk: assert property (@(posedge clk) disable iff (rst)
    trig_i && !veto_o && !host_rst_i |=> veto_o && start_meas_o);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_meas_o |=> !start_meas_o);
  // R3
  start_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
    start_meas_o |-> $past(!veto_o) && $past(trig_i));
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o && !read_done_i && !host_rst_i |=> irq_o);
  // R8
  host_rst_chk: assert property (@(posedge clk) disable iff (rst)
    host_rst_i |=> veto_o && !irq_o && !start_meas_o);
  // R4
  veto_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(veto_o) |-> clr_trig_o && $past(dig_ready_i));
  // R4
  clr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_meas_o, clr_trig_o}));
  // R6
  irq_veto_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> veto_o);
endmodule

bind evt_readout_ctrl evt_readout_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .trig_i       (trig_i),
  .host_rst_i   (host_rst_i),
  .dig_ready_i  (dig_ready_i),
  .read_done_i  (read_done_i),
  .veto_o       (veto_o),
  .start_meas_o (start_meas_o),
  .irq_o        (irq_o),
  .clr_trig_o   (clr_trig_o)
);

// File: tb/evt_readout_ctrl_bench.sv
module evt_readout_ctrl_bench;
  localparam int LIMIT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_i = 1'b0, host_rst_i = 1'b0, dig_ready_i = 1'b0, read_done_i = 1'b0;
  logic veto_o, start_meas_o, irq_o, clr_trig_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural reference model
  int ph = 0;
  int n = 0;
  bit e_veto = 0, e_start = 0, e_irq = 0, e_clr = 0;

  always #5 clk = ~clk;

  evt_readout_ctrl #(.EVT_LIMIT(LIMIT)) u_evt_readout_ctrl (
    .clk(clk), .rst(rst), .trig_i(trig_i), .host_rst_i(host_rst_i),
    .dig_ready_i(dig_ready_i), .read_done_i(read_done_i),
    .veto_o(veto_o), .start_meas_o(start_meas_o), .irq_o(irq_o),
    .clr_trig_o(clr_trig_o)
  );

  always @(posedge clk) begin
    e_start = 0;
    e_clr   = 0;
    if (rst) begin
      ph = 0; n = 0; e_veto = 0; e_irq = 0;
    end else if (host_rst_i) begin
      ph = 4; e_veto = 1; e_irq = 0;
    end else if (ph == 0) begin
      if (trig_i) begin
        n = n + 1; e_veto = 1; e_start = 1;
        if (n >= LIMIT) begin e_irq = 1; ph = 2; end
        else ph = 1;
      end
    end else if (ph == 1) begin
      if (dig_ready_i) begin e_veto = 0; e_clr = 1; ph = 0; end
    end else if (ph == 2) begin
      if (read_done_i) begin e_irq = 0; ph = 3; end
    end else if (ph == 4) begin
      if (dig_ready_i) begin e_veto = 0; e_clr = 1; n = 0; ph = 0; end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // model comparison on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2 start_meas_o model", start_meas_o, e_start);
      chk("R4 veto_o model", veto_o, e_veto);
      chk("R5 irq_o model", irq_o, e_irq);
      chk("R7 clr_trig_o model", clr_trig_o, e_clr);
    end
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: trig_i = 1'b1;
      1: host_rst_i = 1'b1;
      2: dig_ready_i = 1'b1;
      3: read_done_i = 1'b1;
      default: begin trig_i = 1'b1; host_rst_i = 1'b1; end
    endcase
    @(negedge clk);
    trig_i = 1'b0; host_rst_i = 1'b0; dig_ready_i = 1'b0; read_done_i = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // trigger then ready, one event below the limit
  task automatic small_event;
    pulse(0);
    chk("R2 veto after trigger", veto_o, 1'b1);
    chk("R2 start pulse", start_meas_o, 1'b1);
    chk("R4 no irq below limit", irq_o, 1'b0);
    pulse(0);
    chk("R3 vetoed trigger no start", start_meas_o, 1'b0);
    pulse(2);
    chk("R4 veto released on ready", veto_o, 1'b0);
    chk("R4 clr_trig pulse", clr_trig_o, 1'b1);
  endtask

  initial begin
    idle(1);
    chk("R1 veto in reset", veto_o, 1'b0);
    chk("R1 irq in reset", irq_o, 1'b0);
    idle(2);
    rst = 1'b0;
    idle(1);
    chk("R1 start after reset", start_meas_o, 1'b0);
    chk("R1 clr after reset", clr_trig_o, 1'b0);

    for (int i = 0; i < LIMIT - 1; i++) small_event();
    pulse(2);
    chk("R9 ready in idle veto", veto_o, 1'b0);
    chk("R9 ready in idle clr", clr_trig_o, 1'b0);
    pulse(3);
    chk("R9 read_done in idle irq", irq_o, 1'b0);

    pulse(0);
    chk("R5 irq on limit event", irq_o, 1'b1);
    chk("R5 start on limit event", start_meas_o, 1'b1);
    idle(4);
    chk("R6 irq held", irq_o, 1'b1);
    pulse(2);
    chk("R6 ready ignored during irq", veto_o, 1'b1);
    pulse(3);
    chk("R6 irq dropped on read_done", irq_o, 1'b0);
    chk("R7 veto kept after read", veto_o, 1'b1);
    pulse(2);
    chk("R7 ready before host reset ignored", veto_o, 1'b1);
    pulse(1);
    chk("R7 veto during recover", veto_o, 1'b1);
    pulse(2);
    chk("R7 veto cleared after reset+ready", veto_o, 1'b0);
    chk("R7 clr pulse at release", clr_trig_o, 1'b1);

    for (int i = 0; i < LIMIT - 1; i++) small_event();
    pulse(0);
    chk("R7 count restarted irq", irq_o, 1'b1);
    pulse(1);
    chk("R8 host reset drops irq", irq_o, 1'b0);
    chk("R8 host reset keeps veto", veto_o, 1'b1);
    pulse(2);
    chk("R8 ready after host reset", veto_o, 1'b0);

    pulse(0);
    pulse(2);
    pulse(0);
    pulse(1);
    chk("R8 host reset in measure", veto_o, 1'b1);
    pulse(2);
    for (int i = 0; i < LIMIT - 1; i++) small_event();
    chk("R8 count cleared no irq", irq_o, 1'b0);
    pulse(4);
    chk("R8 host reset beats trigger", start_meas_o, 1'b0);
    chk("R8 veto on combined pulse", veto_o, 1'b1);
    pulse(2);
    for (int i = 0; i < LIMIT - 1; i++) small_event();
    pulse(0);
    chk("R5 irq after cleared count", irq_o, 1'b1);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule